// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out the hardware side of taking an interrupt on a 16-bit processor with segmented addressing. While it is idle and the interrupt-enable flag is set, it accepts a request. It acknowledges the device with a one-cycle pulse and then captures the 8-bit vector number that the device presents. It saves the flags word, the code segment and the instruction pointer on a word-wide stack in memory and then clears the interrupt-enable flag. Finally it fetches the handler's segment and offset from a vector table in the lowest kilobyte of memory and loads them.

A return request runs the opposite sequence. It pops the instruction pointer, the code segment and the flags word in that order and restores all three exactly, including the enable bit. All memory traffic uses one 20-bit-address, 16-bit-data port with a ready handshake. A done pulse marks the cycle in which the new code segment and instruction pointer are visible on the register outputs.

Top module: `irq_dispatch_seq`

## Requirements
- R1: After reset the outputs show the parameter values for the stack segment, stack pointer, code segment, instruction pointer and flags (defaults 0x3000, 0x0100, 0xF000, 0xFFF0, 0x0202), and irq_ack, done and mem_req are low.
- R2: A request is taken only in the idle state while flags bit 9 (interrupt enable) is 1. When bit 9 is 0, a held request produces no acknowledge and no memory traffic, and the registers do not change.
- R3: irq_ack is high for exactly one cycle. The vector number is sampled from irq_vec in the cycle that directly follows that pulse.
- R4: Entry performs three writes in this order: flags, code segment, instruction pointer. Each write first lowers the stack pointer by 2 and then writes to the linear address stack_segment*16 + stack_pointer, modulo 2^20. After entry the stack pointer is 6 lower.
- R5: Once the three writes complete, flags bit 9 is cleared and every other flag bit keeps its value.
- R6: The vector table starts at address 0. For vector v the block reads the word at 4v+2 and loads it as the new instruction pointer, then reads the word at 4v and loads it as the new code segment.
- R7: Every memory step holds mem_req, mem_we, mem_addr and mem_wdata steady until a cycle with mem_rdy high, and moves to the next step only in that cycle.
- R8: done is a one-cycle pulse in the cycle that follows the final load. In that cycle cs_out and ip_out already show the new values.
- R9: A return pops three words from stack_segment*16 + stack_pointer, adding 2 to the stack pointer after each. The words go, in order, to the instruction pointer, the code segment and the flags. All three are restored exactly.
- R10: If a return request and an enabled interrupt request arrive in the same idle cycle, the return runs first. No acknowledge is issued until that return has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Interrupt request level |
| irq_ack | output | 1 | One-cycle acknowledge to the device |
| irq_vec | input | 8 | Vector number from the device |
| ret_req | input | 1 | Start the return sequence |
| mem_req | output | 1 | Memory access active |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Linear byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid when mem_rdy is high |
| mem_rdy | input | 1 | Access completes this cycle |
| cs_out | output | 16 | Code segment |
| ip_out | output | 16 | Instruction pointer |
| ss_out | output | 16 | Stack segment |
| sp_out | output | 16 | Stack pointer |
| flags_out | output | 16 | Flags word, bit 9 = interrupt enable |
| done | output | 1 | New code segment and instruction pointer are valid |

## Verification
A return request and an enabled interrupt request can both be present in the same idle cycle. To provoke this, the bench drives both on one edge right after reset, with the enable bit set and a prepared frame on the stack. It judges the outcome by checking that the three pops finish and the state is restored before any acknowledge appears. The request is held throughout, so it must then be taken once the restored flags re-enable interrupts. A behavioural model in the bench tracks the expected registers and memory transfers, and every idle clock is compared against it.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ACK,
    S_LATCH,
    S_PUSH_F,
    S_PUSH_CS,
    S_PUSH_IP,
    S_RD_OFF,
    S_RD_SEG,
    S_POP_IP,
    S_POP_CS,
    S_POP_F,
    S_FIN
  } seq_state_e;

  localparam int WORD_BYTES = 2;

  function automatic logic is_push(input seq_state_e s);
    return (s == S_PUSH_F) || (s == S_PUSH_CS) || (s == S_PUSH_IP);
  endfunction

  function automatic logic is_mem(input seq_state_e s);
    return is_push(s) || (s == S_RD_OFF) || (s == S_RD_SEG) ||
           (s == S_POP_IP) || (s == S_POP_CS) || (s == S_POP_F);
  endfunction

endpackage

// File: rtl/irq_seq_rstsync.sv
module irq_seq_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_req,
  input  logic       ret_req,
  input  logic       int_en,
  input  logic       mem_rdy,
  output seq_state_e state_q
);

  seq_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (ret_req)               state_d = S_POP_IP;
        else if (irq_req && int_en) state_d = S_ACK;
      end
      S_ACK:     state_d = S_LATCH;
      S_LATCH:   state_d = S_PUSH_F;
      S_PUSH_F:  if (mem_rdy) state_d = S_PUSH_CS;
      S_PUSH_CS: if (mem_rdy) state_d = S_PUSH_IP;
      S_PUSH_IP: if (mem_rdy) state_d = S_RD_OFF;
      S_RD_OFF:  if (mem_rdy) state_d = S_RD_SEG;
      S_RD_SEG:  if (mem_rdy) state_d = S_FIN;
      S_POP_IP:  if (mem_rdy) state_d = S_POP_CS;
      S_POP_CS:  if (mem_rdy) state_d = S_POP_F;
      S_POP_F:   if (mem_rdy) state_d = S_FIN;
      S_FIN:     state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/irq_seq_addr.sv
module irq_seq_addr
  import irq_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SEG_SHIFT = 4,
  parameter int VEC_W     = 8
) (
  input  seq_state_e                    state,
  input  logic [DATA_W-1:0]             ss,
  input  logic [DATA_W-1:0]             sp,
  input  logic [VEC_W-1:0]              vec,
  output logic [DATA_W+SEG_SHIFT-1:0]   addr,
  output logic [DATA_W-1:0]             sp_dec,
  output logic [DATA_W-1:0]             sp_inc
);

  localparam int ADDR_W = DATA_W + SEG_SHIFT;

  logic [ADDR_W-1:0] stk_base;
  logic [ADDR_W-1:0] push_addr;
  logic [ADDR_W-1:0] pop_addr;
  logic [ADDR_W-1:0] tbl_off_addr;
  logic [ADDR_W-1:0] tbl_seg_addr;

  assign sp_dec       = sp - DATA_W'(WORD_BYTES);
  assign sp_inc       = sp + DATA_W'(WORD_BYTES);
  assign stk_base     = {ss, {SEG_SHIFT{1'b0}}};
  assign push_addr    = stk_base + ADDR_W'(sp_dec);
  assign pop_addr     = stk_base + ADDR_W'(sp);
  assign tbl_off_addr = ADDR_W'({vec, 2'b10});
  assign tbl_seg_addr = ADDR_W'({vec, 2'b00});

  always_comb begin
    unique case (state)
      S_PUSH_F, S_PUSH_CS, S_PUSH_IP: addr = push_addr;
      S_POP_IP, S_POP_CS, S_POP_F:    addr = pop_addr;
      S_RD_OFF:                       addr = tbl_off_addr;
      S_RD_SEG:                       addr = tbl_seg_addr;
      default:                        addr = '0;
    endcase
  end

endmodule

// File: rtl/irq_dispatch_seq.sv
module irq_dispatch_seq
  import irq_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SEG_SHIFT = 4,
  parameter int VEC_W     = 8,
  parameter int IF_BIT    = 9,
  parameter logic [DATA_W-1:0] RST_SS    = 16'h3000,
  parameter logic [DATA_W-1:0] RST_SP    = 16'h0100,
  parameter logic [DATA_W-1:0] RST_CS    = 16'hF000,
  parameter logic [DATA_W-1:0] RST_IP    = 16'hFFF0,
  parameter logic [DATA_W-1:0] RST_FLAGS = 16'h0202
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        irq_req,
  output logic                        irq_ack,
  input  logic [VEC_W-1:0]            irq_vec,
  input  logic                        ret_req,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [DATA_W+SEG_SHIFT-1:0] mem_addr,
  output logic [DATA_W-1:0]           mem_wdata,
  input  logic [DATA_W-1:0]           mem_rdata,
  input  logic                        mem_rdy,
  output logic [DATA_W-1:0]           cs_out,
  output logic [DATA_W-1:0]           ip_out,
  output logic [DATA_W-1:0]           ss_out,
  output logic [DATA_W-1:0]           sp_out,
  output logic [DATA_W-1:0]           flags_out,
  output logic                        done
);

  localparam logic [DATA_W-1:0] IF_MASK = DATA_W'(1) << IF_BIT;

  logic              rst_n_s;
  seq_state_e        state_q;
  logic [DATA_W-1:0] cs_q, cs_d;
  logic [DATA_W-1:0] ip_q, ip_d;
  logic [DATA_W-1:0] sp_q, sp_d;
  logic [DATA_W-1:0] flags_q, flags_d;
  logic [DATA_W-1:0] off_q, off_d;
  logic [VEC_W-1:0]  vec_q, vec_d;
  logic [DATA_W-1:0] sp_dec, sp_inc;

  irq_seq_rstsync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_n_s)
  );

  irq_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .irq_req (irq_req),
    .ret_req (ret_req),
    .int_en  (flags_q[IF_BIT]),
    .mem_rdy (mem_rdy),
    .state_q (state_q)
  );

  irq_seq_addr #(
    .DATA_W    (DATA_W),
    .SEG_SHIFT (SEG_SHIFT),
    .VEC_W     (VEC_W)
  ) u_addr (
    .state  (state_q),
    .ss     (RST_SS),
    .sp     (sp_q),
    .vec    (vec_q),
    .addr   (mem_addr),
    .sp_dec (sp_dec),
    .sp_inc (sp_inc)
  );

  // memory port and handshake outputs, decoded from the current step
  assign mem_req = is_mem(state_q);
  assign mem_we  = is_push(state_q);
  assign irq_ack = (state_q == S_ACK);
  assign done    = (state_q == S_FIN);

  always_comb begin
    unique case (state_q)
      S_PUSH_F:  mem_wdata = flags_q;
      S_PUSH_CS: mem_wdata = cs_q;
      S_PUSH_IP: mem_wdata = ip_q;
      default:   mem_wdata = '0;
    endcase
  end

  // architectural register next values
  always_comb begin
    cs_d    = cs_q;
    ip_d    = ip_q;
    sp_d    = sp_q;
    flags_d = flags_q;
    off_d   = off_q;
    vec_d   = vec_q;
    unique case (state_q)
      S_LATCH: vec_d = irq_vec;
      S_PUSH_F, S_PUSH_CS: begin
        if (mem_rdy) sp_d = sp_dec;
      end
      S_PUSH_IP: begin
        if (mem_rdy) begin
          sp_d    = sp_dec;
          flags_d = flags_q & ~IF_MASK;
        end
      end
      S_RD_OFF: begin
        if (mem_rdy) off_d = mem_rdata;
      end
      S_RD_SEG: begin
        if (mem_rdy) begin
          ip_d = off_q;
          cs_d = mem_rdata;
        end
      end
      S_POP_IP: begin
        if (mem_rdy) begin
          ip_d = mem_rdata;
          sp_d = sp_inc;
        end
      end
      S_POP_CS: begin
        if (mem_rdy) begin
          cs_d = mem_rdata;
          sp_d = sp_inc;
        end
      end
      S_POP_F: begin
        if (mem_rdy) begin
          flags_d = mem_rdata;
          sp_d    = sp_inc;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cs_q    <= RST_CS;
      ip_q    <= RST_IP;
      sp_q    <= RST_SP;
      flags_q <= RST_FLAGS;
      off_q   <= '0;
      vec_q   <= '0;
    end else begin
      cs_q    <= cs_d;
      ip_q    <= ip_d;
      sp_q    <= sp_d;
      flags_q <= flags_d;
      off_q   <= off_d;
      vec_q   <= vec_d;
    end
  end

  assign cs_out    = cs_q;
  assign ip_out    = ip_q;
  assign ss_out    = RST_SS;
  assign sp_out    = sp_q;
  assign flags_out = flags_q;

endmodule

// File: rtl/irq_dispatch_seq_chk.sv
module irq_dispatch_seq_chk #(
  parameter int DATA_W    = 16,
  parameter int SEG_SHIFT = 4,
  parameter int VEC_W     = 8,
  parameter int IF_BIT    = 9
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        irq_ack,
  input logic                        done,
  input logic                        mem_req,
  input logic                        mem_we,
  input logic                        mem_rdy,
  input logic [DATA_W+SEG_SHIFT-1:0] mem_addr,
  input logic [DATA_W-1:0]           mem_wdata,
  input logic [DATA_W-1:0]           ss_out,
  input logic [DATA_W-1:0]           sp_out,
  input logic [DATA_W-1:0]           flags_out
);

  localparam int ADDR_W = DATA_W + SEG_SHIFT;

  logic in_entry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       in_entry_q <= 1'b0;
    else if (irq_ack) in_entry_q <= 1'b1;
    else if (done)    in_entry_q <= 1'b0;
  end

  // R2
  ack_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> flags_out[IF_BIT]);

  // R3
  ack_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  // R4
  push_address_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |->
      (mem_addr == ({ss_out, {SEG_SHIFT{1'b0}}} + ADDR_W'(sp_out - DATA_W'(2)))));

  // R5
  enable_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && in_entry_q) |-> !flags_out[IF_BIT]);

  // R6
  table_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && in_entry_q) |-> (mem_addr[ADDR_W-1:VEC_W+2] == '0));

  // R7
  hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R8
  done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind irq_dispatch_seq irq_dispatch_seq_chk #(
  .DATA_W    (DATA_W),
  .SEG_SHIFT (SEG_SHIFT),
  .VEC_W     (VEC_W),
  .IF_BIT    (IF_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_ack   (irq_ack),
  .done      (done),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_rdy   (mem_rdy),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .ss_out    (ss_out),
  .sp_out    (sp_out),
  .flags_out (flags_out)
);

// File: tb/irq_dispatch_seq_bench.sv
`timescale 1ns/1ps
module irq_dispatch_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_req, ret_req, irq_ack;
  logic [7:0]  irq_vec;
  logic        mem_req, mem_we, mem_rdy;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [15:0] cs_out, ip_out, ss_out, sp_out, flags_out;
  logic        done;

  always #4 clk = ~clk;

  irq_dispatch_seq u_irq_dispatch_seq (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
    .irq_vec(irq_vec), .ret_req(ret_req), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rdy(mem_rdy), .cs_out(cs_out), .ip_out(ip_out), .ss_out(ss_out),
    .sp_out(sp_out), .flags_out(flags_out), .done(done)
  );

  typedef struct { bit we; int addr; int data; } xact_t;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] mem [int];
  xact_t obs[$];
  xact_t expq[$];
  int wait_left = 0;
  int pat = 0;
  bit model_idle = 0;
  int m_cs, m_ip, m_ss, m_sp, m_flags;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int lin(input int seg, input int off);
    return ((seg << 4) + (off & 'hFFFF)) & 'hFFFFF;
  endfunction

  function automatic logic [15:0] rd(input int a);
    if (mem.exists(a)) return mem[a];
    return 16'(a ^ 32'hA5C3);
  endfunction

  // memory with varying wait states
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rdy = 1'b0;
      wait_left = 0;
    end else if (mem_rdy) begin
      mem_rdy = 1'b0;
      wait_left = pat % 3;
      pat++;
    end else if (mem_req) begin
      if (wait_left == 0) begin
        mem_rdy = 1'b1;
        if (mem_we) begin
          mem[int'(mem_addr)] = mem_wdata;
          obs.push_back('{1'b1, int'(mem_addr), int'(mem_wdata)});
        end else begin
          mem_rdata = rd(int'(mem_addr));
          obs.push_back('{1'b0, int'(mem_addr), int'(mem_rdata)});
        end
      end else begin
        wait_left--;
      end
    end
  end

  // per-clock comparison against the model while no operation is running
  always @(negedge clk) begin
    if (model_idle) begin
      chk(int'(cs_out) == m_cs && int'(ip_out) == m_ip && int'(sp_out) == m_sp &&
          int'(flags_out) == m_flags, "R2", "idle registers steady",
          int'(sp_out), m_sp);
      chk(!mem_req && !irq_ack && !done, "R2", "idle port quiet",
          int'({mem_req, irq_ack, done}), 0);
    end
  end

  task automatic cmp_xacts(input string req);
    chk(obs.size() == expq.size(), req, "transfer count", obs.size(), expq.size());
    for (int i = 0; i < expq.size() && i < obs.size(); i++) begin
      chk(obs[i].we == expq[i].we && obs[i].addr == expq[i].addr &&
          obs[i].data == expq[i].data, req, "transfer addr/data",
          obs[i].addr, expq[i].addr);
    end
  endtask

  task automatic do_entry(input logic [7:0] v, input bit irq_pre);
    int sp0;
    int nf;
    bit seen;
    model_idle = 0;
    obs.delete();
    expq.delete();
    sp0 = m_sp;
    expq.push_back('{1'b1, lin(m_ss, sp0 - 2), m_flags});
    expq.push_back('{1'b1, lin(m_ss, sp0 - 4), m_cs});
    expq.push_back('{1'b1, lin(m_ss, sp0 - 6), m_ip});
    expq.push_back('{1'b0, int'(v) * 4 + 2, int'(rd(int'(v) * 4 + 2))});
    expq.push_back('{1'b0, int'(v) * 4, int'(rd(int'(v) * 4))});
    if (!irq_pre) irq_req = 1'b1;
    seen = 0;
    for (int i = 0; i < 60 && !seen; i++) begin
      @(negedge clk);
      if (irq_ack) seen = 1;
    end
    chk(seen, "R2", "acknowledge for enabled request", int'(seen), 1);
    irq_req = 1'b0;
    @(negedge clk);
    chk(!irq_ack, "R3", "acknowledge lasts one cycle", int'(irq_ack), 0);
    irq_vec = v;            // vector valid only in the cycle after the pulse
    @(negedge clk);
    irq_vec = 8'hC3;
    seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      if (done) seen = 1;
      else @(negedge clk);
    end
    chk(seen, "R8", "done after entry", int'(seen), 1);
    chk(int'(ip_out) == int'(rd(int'(v) * 4 + 2)), "R6", "handler offset",
        int'(ip_out), int'(rd(int'(v) * 4 + 2)));
    chk(int'(cs_out) == int'(rd(int'(v) * 4)), "R6", "handler segment",
        int'(cs_out), int'(rd(int'(v) * 4)));
    chk(int'(sp_out) == ((sp0 - 6) & 'hFFFF), "R4", "stack pointer after entry",
        int'(sp_out), (sp0 - 6) & 'hFFFF);
    nf = m_flags & ~(1 << 9);
    chk(int'(flags_out) == nf, "R5", "enable bit cleared", int'(flags_out), nf);
    cmp_xacts("R4");
    chk(int'(rd(lin(m_ss, sp0 - 2))) == m_flags, "R4", "stacked flags",
        int'(rd(lin(m_ss, sp0 - 2))), m_flags);
    chk(int'(rd(lin(m_ss, sp0 - 4))) == m_cs, "R4", "stacked segment",
        int'(rd(lin(m_ss, sp0 - 4))), m_cs);
    chk(int'(rd(lin(m_ss, sp0 - 6))) == m_ip, "R4", "stacked pointer",
        int'(rd(lin(m_ss, sp0 - 6))), m_ip);
    m_ip = int'(rd(int'(v) * 4 + 2));
    m_cs = int'(rd(int'(v) * 4));
    m_sp = (sp0 - 6) & 'hFFFF;
    m_flags = nf;
    @(negedge clk);
    chk(!done, "R8", "done lasts one cycle", int'(done), 0);
    model_idle = 1;
  endtask

  task automatic do_return(input bit with_irq);
    int sp0, a0, a1, a2;
    bit seen, acked;
    model_idle = 0;
    obs.delete();
    expq.delete();
    sp0 = m_sp;
    a0 = lin(m_ss, sp0);
    a1 = lin(m_ss, sp0 + 2);
    a2 = lin(m_ss, sp0 + 4);
    expq.push_back('{1'b0, a0, int'(rd(a0))});
    expq.push_back('{1'b0, a1, int'(rd(a1))});
    expq.push_back('{1'b0, a2, int'(rd(a2))});
    ret_req = 1'b1;
    if (with_irq) irq_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    seen = 0;
    acked = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      if (irq_ack) acked = 1;
      if (done) seen = 1;
      else @(negedge clk);
    end
    chk(seen, "R9", "done after return", int'(seen), 1);
    chk(!acked, "R10", "no acknowledge during return", int'(acked), 0);
    chk(int'(ip_out) == int'(rd(a0)), "R9", "restored pointer", int'(ip_out), int'(rd(a0)));
    chk(int'(cs_out) == int'(rd(a1)), "R9", "restored segment", int'(cs_out), int'(rd(a1)));
    chk(int'(flags_out) == int'(rd(a2)), "R9", "restored flags", int'(flags_out), int'(rd(a2)));
    chk(int'(sp_out) == ((sp0 + 6) & 'hFFFF), "R9", "stack pointer after return",
        int'(sp_out), (sp0 + 6) & 'hFFFF);
    cmp_xacts("R9");
    m_ip = int'(rd(a0));
    m_cs = int'(rd(a1));
    m_flags = int'(rd(a2));
    m_sp = (sp0 + 6) & 'hFFFF;
    if (!with_irq) begin
      @(negedge clk);
      chk(!done, "R8", "done lasts one cycle", int'(done), 0);
      model_idle = 1;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit got;
    rst_n = 1'b0;
    irq_req = 1'b0;
    ret_req = 1'b0;
    irq_vec = 8'hC3;
    mem_rdata = 16'h0;
    mem_rdy = 1'b0;
    // table entries for the three vectors under test
    for (int v = 0; v < 256; v += 255) begin
      mem[v * 4 + 2] = 16'(16'h1000 + v);
      mem[v * 4]     = 16'(16'h2000 + v);
    end
    mem['h5A * 4 + 2] = 16'h1A5A;
    mem['h5A * 4]     = 16'h2B5A;
    // a prepared frame above the reset stack pointer
    mem['h30100] = 16'h1111;
    mem['h30102] = 16'h2222;
    mem['h30104] = 16'h0283;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(ss_out == 16'h3000, "R1", "reset stack segment", int'(ss_out), 'h3000);
    chk(sp_out == 16'h0100, "R1", "reset stack pointer", int'(sp_out), 'h0100);
    chk(cs_out == 16'hF000, "R1", "reset code segment", int'(cs_out), 'hF000);
    chk(ip_out == 16'hFFF0, "R1", "reset pointer", int'(ip_out), 'hFFF0);
    chk(flags_out == 16'h0202, "R1", "reset flags", int'(flags_out), 'h0202);
    chk(!irq_ack && !done && !mem_req, "R1", "reset outputs low",
        int'({irq_ack, done, mem_req}), 0);
    m_ss = 'h3000; m_sp = 'h0100; m_cs = 'hF000; m_ip = 'hFFF0; m_flags = 'h0202;
    model_idle = 1;

    // R10 return and enabled request in the same idle cycle
    do_return(1'b1);
    do_entry(8'h5A, 1'b1);
    do_return(1'b0);

    // R6 lowest vector, then round trip
    do_entry(8'h00, 1'b0);
    do_return(1'b0);

    // R6 highest vector; R2 request ignored while disabled
    do_entry(8'hFF, 1'b0);
    irq_req = 1'b1;
    got = 0;
    repeat (12) begin
      @(negedge clk);
      if (irq_ack || mem_req) got = 1;
    end
    irq_req = 1'b0;
    chk(!got, "R2", "request ignored with enable clear", int'(got), 0);
    chk(int'(sp_out) == m_sp, "R2", "stack untouched while disabled", int'(sp_out), m_sp);
    do_return(1'b0);

    chk(cs_out == 16'h2222 && ip_out == 16'h1111 && flags_out == 16'h0283,
        "R9", "state after all round trips", int'(ip_out), 'h1111);
    chk(sp_out == 16'h0106, "R9", "final stack pointer", int'(sp_out), 'h0106);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule